// File: doc/BRIEF.md
# ASCII Hex Frame LRC Generator and Checker

This block computes the longitudinal redundancy check of a serial frame sent in ASCII-hex form. Characters arrive on a valid/ready stream. Each pair of hex characters becomes one byte, with the first character of the pair as the upper nibble. The bytes are summed modulo 256, and the check value is the two's-complement negation of that sum. The stream covers the address field through the last data character. The start delimiter, the trailing check characters and the line terminator are handled outside the block.

When the character flagged as end of frame is accepted, the block forms the check value as two uppercase ASCII hex characters, upper nibble first. In generate mode these two characters are the result. In check mode the block then takes the next two characters on the same stream as the received check pair, compares them with the computed pair and reports pass or fail. Either way a one-cycle `res_valid` pulse ends the frame.

Back-pressure rules: `in_ready` is high in every cycle except the cycle in which `res_valid` is high. A character is transferred on a clock edge where `in_valid` and `in_ready` are both high. The sender must hold `in_char`, `in_sof` and `in_eof` stable while `in_valid` is high and `in_ready` is low. `in_sof` and `in_eof` are only sampled when a character is transferred.

Top module: `lrc_ascii_unit`

## Requirements
- R1: After reset, `res_valid`, `res_fmt_err`, `res_checked` and `res_pass` are 0 and `in_ready` is 1.
- R2: Hex characters '0'-'9' (30h-39h) and uppercase 'A'-'F' (41h-46h) are decoded. Each consecutive pair forms a byte, with the first character as the upper nibble. The bytes are summed modulo 256, so carries out of bit 7 are lost.
- R3: The check value is (256 - sum) mod 256. When no format error occurs, `res_hi` and `res_lo` carry it as uppercase ASCII hex, upper nibble in `res_hi`. In generate mode `res_valid` is high in the cycle right after the edge that accepts the end-of-frame character. For example, bytes 01h 03h 21h 02h 00h 02h give "D7".
- R4: A transferred character with `in_sof` high starts a new frame. It clears the sum to 00h, the pairing position and the format error. This applies both between frames and in the middle of an open frame.
- R5: Characters transferred while no frame is open (after reset or after a result, before the next `in_sof`) are discarded and have no effect on the next frame's result.
- R6: Any data character outside the two hex ranges of R2, including lowercase 'a'-'f', sets `res_fmt_err` for the rest of the frame.
- R7: If a frame holds an odd number of data characters, `res_fmt_err` is 1 in its result.
- R8: `chk_mode` is sampled when the end-of-frame character is accepted. If it is 1, the next two transferred characters are the received check pair, upper character first. `res_valid` then rises in the cycle after the second one, with `res_checked` = 1. `res_pass` = 1 only when both characters equal the computed pair exactly and `res_fmt_err` is 0.
- R9: In generate mode, `res_checked` and `res_pass` are 0 in the result.
- R10: `res_valid` lasts exactly one cycle, `in_ready` is low during that cycle, and a character held through it is transferred afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_mode | input | 1 | 1 selects check mode, sampled at end of frame |
| in_valid | input | 1 | Character stream valid |
| in_ready | output | 1 | Character stream ready |
| in_char | input | 8 | ASCII character |
| in_sof | input | 1 | Character opens a new frame |
| in_eof | input | 1 | Character is the last data character |
| res_valid | output | 1 | One-cycle result strobe |
| res_hi | output | 8 | Computed check character, upper nibble |
| res_lo | output | 8 | Computed check character, lower nibble |
| res_fmt_err | output | 1 | Frame had a non-hex or odd-count character stream |
| res_checked | output | 1 | Result comes from check mode |
| res_pass | output | 1 | Received check pair matched and the frame was clean |

## Verification
The main sweep sends every byte value 00h-FFh as a single-byte frame. This covers every check value and every nibble-to-character case, digits and letters alike. A second sweep sends every byte value twice in one frame. Its sums wrap past 255 for half the values, which shows whether carries are dropped.

A third sweep runs every byte in check mode with the correct check pair, and the bench then flips one received character. This separates a true comparison from a constant pass. The six-byte example frame, plus directed frames with odd length, a non-hex character, a lowercase letter, a restart in mid-frame and characters sent with no frame open, covers pairing order, error stickiness and clearing.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  localparam int CHAR_W = 8;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_CHK_HI,
    ST_CHK_LO,
    ST_DONE
  } lrc_state_t;

  // {ok, nibble}; ok is 0 for anything outside 0-9 / A-F
  function automatic logic [NIB_W:0] hex_decode(input logic [CHAR_W-1:0] c);
    logic [NIB_W:0] r;
    if (c >= 8'h30 && c <= 8'h39)
      r = {1'b1, c[NIB_W-1:0]};
    else if (c >= 8'h41 && c <= 8'h46)
      r = {1'b1, c[NIB_W-1:0] + 4'd9};
    else
      r = '0;
    return r;
  endfunction

  function automatic logic [CHAR_W-1:0] nib_to_ascii(input logic [NIB_W-1:0] n);
    logic [CHAR_W-1:0] r;
    if (n < 4'd10)
      r = 8'h30 + {4'h0, n};
    else
      r = 8'h37 + {4'h0, n};
    return r;
  endfunction
endpackage

// File: rtl/lrc_hex_pair.sv
module lrc_hex_pair
  import lrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [CHAR_W-1:0] ch,
  output logic              pair_done,
  output logic [BYTE_W-1:0] pair_byte,
  output logic              bad,
  output logic              half_open
);
  logic             phase_q;
  logic [NIB_W-1:0] hi_q;
  logic [NIB_W:0]   dec;
  logic             phase_eff;

  always_comb begin
    dec       = hex_decode(ch);
    phase_eff = phase_q & ~clr;
    pair_done = step & phase_eff;
    pair_byte = {hi_q, dec[NIB_W-1:0]};
    bad       = step & ~dec[NIB_W];
    half_open = phase_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      hi_q    <= '0;
    end else if (step) begin
      phase_q <= ~phase_eff;
      if (!phase_eff) hi_q <= dec[NIB_W-1:0];
    end
  end
endmodule

// File: rtl/lrc_sum_acc.sv
module lrc_sum_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add,
  input  logic [W-1:0] addend,
  output logic [W-1:0] sum_next
);
  logic [W-1:0] sum_q;
  logic [W-1:0] base;

  always_comb begin
    base     = clr ? '0 : sum_q;
    sum_next = add ? base + addend : base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sum_q <= '0;
    else if (clr || add) sum_q <= sum_next;
  end
endmodule

// File: rtl/lrc_frame_ctrl.sv
module lrc_frame_ctrl
  import lrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_mode,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              bad,
  input  logic              half_open,
  input  logic [BYTE_W-1:0] sum_next,
  output logic              in_ready,
  output logic              clr,
  output logic              take,
  output logic              res_valid,
  output logic [CHAR_W-1:0] res_hi,
  output logic [CHAR_W-1:0] res_lo,
  output logic              res_fmt_err,
  output logic              res_checked,
  output logic              res_pass
);
  lrc_state_t        st_q;
  logic              err_q, err_next;
  logic              acc, open;
  logic [BYTE_W-1:0] lrc;
  logic [CHAR_W-1:0] rx_hi_q;

  always_comb begin
    in_ready  = (st_q != ST_DONE);
    acc       = in_valid & in_ready;
    open      = (st_q == ST_IDLE) | (st_q == ST_FRAME);
    clr       = acc & in_sof & open;
    take      = acc & ((st_q == ST_FRAME) | clr);
    err_next  = (clr ? 1'b0 : err_q) | bad;
    lrc       = BYTE_W'(0) - sum_next;
    res_valid = (st_q == ST_DONE);
    res_fmt_err = err_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      err_q       <= 1'b0;
      rx_hi_q     <= '0;
      res_hi      <= '0;
      res_lo      <= '0;
      res_checked <= 1'b0;
      res_pass    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE, ST_FRAME: begin
          if (take) begin
            if (in_eof) begin
              err_q       <= err_next | ~half_open;
              res_hi      <= nib_to_ascii(lrc[BYTE_W-1:NIB_W]);
              res_lo      <= nib_to_ascii(lrc[NIB_W-1:0]);
              res_checked <= chk_mode;
              res_pass    <= 1'b0;
              st_q        <= chk_mode ? ST_CHK_HI : ST_DONE;
            end else begin
              err_q <= err_next;
              st_q  <= ST_FRAME;
            end
          end
        end
        ST_CHK_HI: begin
          if (acc) begin
            rx_hi_q <= in_char;
            st_q    <= ST_CHK_LO;
          end
        end
        ST_CHK_LO: begin
          if (acc) begin
            res_pass <= (rx_hi_q == res_hi) && (in_char == res_lo) && !err_q;
            st_q     <= ST_DONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lrc_ascii_unit.sv
module lrc_ascii_unit
  import lrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              res_valid,
  output logic [CHAR_W-1:0] res_hi,
  output logic [CHAR_W-1:0] res_lo,
  output logic              res_fmt_err,
  output logic              res_checked,
  output logic              res_pass
);
  logic              clr, take, pair_done, bad, half_open;
  logic [BYTE_W-1:0] pair_byte, sum_next;

  lrc_hex_pair u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .step      (take),
    .ch        (in_char),
    .pair_done (pair_done),
    .pair_byte (pair_byte),
    .bad       (bad),
    .half_open (half_open)
  );

  lrc_sum_acc #(.W(BYTE_W)) u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .add      (pair_done),
    .addend   (pair_byte),
    .sum_next (sum_next)
  );

  lrc_frame_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_mode    (chk_mode),
    .in_valid    (in_valid),
    .in_char     (in_char),
    .in_sof      (in_sof),
    .in_eof      (in_eof),
    .bad         (bad),
    .half_open   (half_open),
    .sum_next    (sum_next),
    .in_ready    (in_ready),
    .clr         (clr),
    .take        (take),
    .res_valid   (res_valid),
    .res_hi      (res_hi),
    .res_lo      (res_lo),
    .res_fmt_err (res_fmt_err),
    .res_checked (res_checked),
    .res_pass    (res_pass)
  );
endmodule

// File: rtl/lrc_ascii_sva.sv
module lrc_ascii_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_eof,
  input logic       res_valid,
  input logic [7:0] res_hi,
  input logic [7:0] res_lo,
  input logic       res_fmt_err,
  input logic       res_checked,
  input logic       res_pass
);
  function automatic logic up_hex(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46);
  endfunction

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r10_stall_on_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready);

  a_r9_gen_never_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_checked) |-> !res_pass);

  a_r8_pass_needs_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pass) |-> !res_fmt_err);

  a_r3_uppercase_hex_out: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fmt_err) |-> (up_hex(res_hi) && up_hex(res_lo)));

  a_r3_follows_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_checked) |-> $past(in_valid && in_ready && in_eof));

  a_r8_follows_check_char: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_checked) |-> $past(in_valid && in_ready));
endmodule

bind lrc_ascii_unit lrc_ascii_sva u_sva (.*);

// File: tb/lrc_ascii_unit_test.sv
`timescale 1ns/1ps
module lrc_ascii_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chk_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_char = 8'h00;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic       res_valid;
  logic [7:0] res_hi, res_lo;
  logic       res_fmt_err, res_checked, res_pass;

  int n_total = 0;
  int n_fail  = 0;
  logic [7:0] bq [0:7];

  always #2.5 clk = ~clk;

  lrc_ascii_unit uut (.*);

  function automatic logic [7:0] hexc(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + {4'h0, n} : 8'h41 + {4'h0, n} - 8'd10;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] c, input logic s, input logic e);
    in_char = c; in_sof = s; in_eof = e; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  // Called at the negedge where the result should be showing.
  task automatic finish(input string req, input logic e_err, input logic e_chk,
                        input logic e_pass);
    chk({req, " res_valid"}, res_valid, 1);
    chk({req, " R10 ready low"}, in_ready, 0);
    chk({req, " fmt_err"}, res_fmt_err, e_err);
    chk({req, " checked"}, res_checked, e_chk);
    chk({req, " pass"}, res_pass, e_pass);
    @(negedge clk);
    chk({req, " R10 one-cycle"}, res_valid, 0);
  endtask

  task automatic run_bytes(input int n, input bit cm, input bit good, input string req);
    logic [7:0] sum, lrc, eh, el;
    sum = 8'h00;
    for (int i = 0; i < n; i++) sum = sum + bq[i];
    lrc = 8'h00 - sum;
    eh = hexc(lrc[7:4]);
    el = hexc(lrc[3:0]);
    chk_mode = cm;
    for (int i = 0; i < n; i++) begin
      send_char(hexc(bq[i][7:4]), i == 0, 1'b0);
      send_char(hexc(bq[i][3:0]), 1'b0, i == n - 1);
    end
    if (cm) begin
      chk_mode = 1'b0;  // R8: mode already latched at end of frame
      send_char(eh, 1'b0, 1'b0);
      send_char(good ? el : (el ^ 8'h01), 1'b0, 1'b0);
    end
    chk({req, " R3 hi"}, res_hi, eh);
    chk({req, " R3 lo"}, res_lo, el);
    finish(req, 1'b0, cm, cm & good);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_total++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 fmt_err", res_fmt_err, 0);
    chk("R1 checked", res_checked, 0);
    chk("R1 pass", res_pass, 0);

    // Worked example: sum 29h -> D7h
    bq[0] = 8'h01; bq[1] = 8'h03; bq[2] = 8'h21;
    bq[3] = 8'h02; bq[4] = 8'h00; bq[5] = 8'h02;
    run_bytes(6, 1'b0, 1'b1, "R2 R3 example");
    chk("R3 example literal", {res_hi, res_lo}, {8'h44, 8'h37});

    // Sweep: every single byte, generate mode (R3, R9)
    for (int b = 0; b < 256; b++) begin
      bq[0] = 8'(b);
      run_bytes(1, 1'b0, 1'b1, "R3 R9 single");
    end
    // Sweep: byte repeated, wraps modulo 256 (R2)
    for (int b = 0; b < 256; b++) begin
      bq[0] = 8'(b); bq[1] = 8'(b);
      run_bytes(2, 1'b0, 1'b1, "R2 wrap");
    end
    // Sweep: check mode, correct pair (R8)
    for (int b = 0; b < 256; b++) begin
      bq[0] = 8'(b);
      run_bytes(1, 1'b1, 1'b1, "R8 match");
    end
    // Check mode, wrong pair
    for (int b = 0; b < 256; b += 17) begin
      bq[0] = 8'(b); bq[1] = 8'h5A;
      run_bytes(2, 1'b1, 1'b0, "R8 mismatch");
    end

    // R7: odd number of characters
    chk_mode = 1'b0;
    send_char("1", 1'b1, 1'b0);
    send_char("2", 1'b0, 1'b0);
    send_char("3", 1'b0, 1'b1);
    finish("R7 odd", 1'b1, 1'b0, 1'b0);

    // R6: non-hex character, error sticks to end
    send_char("G", 1'b1, 1'b0);
    send_char("0", 1'b0, 1'b0);
    send_char("1", 1'b0, 1'b0);
    send_char("2", 1'b0, 1'b1);
    finish("R6 non-hex", 1'b1, 1'b0, 1'b0);

    // R6: lowercase letter in check mode, correct pair still fails
    chk_mode = 1'b1;
    send_char("0", 1'b1, 1'b0);
    send_char("a", 1'b0, 1'b1);
    send_char("F", 1'b0, 1'b0);
    send_char("6", 1'b0, 1'b0);
    finish("R6 R8 lowercase", 1'b1, 1'b1, 1'b0);
    chk_mode = 1'b0;

    // R4: clean frame after an error frame has no error
    bq[0] = 8'h10;
    run_bytes(1, 1'b0, 1'b1, "R4 err cleared");

    // R4: restart mid-frame (odd count pending, sum nonzero)
    send_char("5", 1'b1, 1'b0);
    send_char("5", 1'b0, 1'b0);
    send_char("7", 1'b0, 1'b0);
    send_char("0", 1'b1, 1'b0);
    send_char("1", 1'b0, 1'b1);
    chk("R4 restart hi", res_hi, 8'h46);
    chk("R4 restart lo", res_lo, 8'h46);
    finish("R4 restart", 1'b0, 1'b0, 1'b0);

    // R5: characters with no frame open are dropped
    send_char("7", 1'b0, 1'b0);
    send_char("7", 1'b0, 1'b1);
    send_char("Z", 1'b0, 1'b0);
    chk("R5 no result", res_valid, 0);
    send_char("8", 1'b1, 1'b0);
    send_char("0", 1'b0, 1'b1);
    chk("R5 hi", res_hi, 8'h38);
    chk("R5 lo", res_lo, 8'h30);
    finish("R5 dropped", 1'b0, 1'b0, 1'b0);

    // R10: character held through the result cycle is taken afterwards
    send_char("0", 1'b1, 1'b0);
    send_char("2", 1'b0, 1'b1);
    in_char = "0"; in_sof = 1'b1; in_eof = 1'b0; in_valid = 1'b1;
    chk("R10 stalled", in_ready, 0);
    @(posedge clk); @(negedge clk);
    chk("R10 ready again", in_ready, 1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    send_char("4", 1'b0, 1'b1);
    chk("R10 held char used hi", res_hi, 8'h46);
    chk("R10 held char used lo", res_lo, 8'h43);
    finish("R10 held", 1'b0, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule